// File: doc/BRIEF.md
# Indexed-Colour Display Controller Register Block

This block holds the programmable state of an 8-bit indexed-colour display controller. A host reaches it through a simple 32-bit word bus with separate read and write strobes and a byte address. The block decodes each access into one of several targets: a 32-bit control word, the visible width and height, a scan-out start offset, a cursor position, a 256-entry colour lookup table, a 3-entry cursor colour table, a 512-word cursor bitmap, and a soft-reset location. Writes to the video timing locations are accepted and discarded.

The stored state drives a pixel pipeline directly. The control word, dimensions, start offset and cursor position are plain outputs, and pixel depth, forced blanking and cursor disable are decoded from control fields. Each of the three tables has a combinational lookup port that the pipeline indexes on its own. Width and height are kept in pixel and line units. Because of this, a write to either one is rescaled on the way in, and a read of it is rescaled on the way out.

An interrupt line rises on a frame-end strobe from the timing logic. Any bus write lowers it, and a write has priority over a frame-end in the same cycle. Read data is registered and appears one cycle after the read strobe.

Top module: `fbreg_top`

## Requirements
- R1: After the asynchronous reset, the interrupt line, the control word, the width, the height, the start offset, the cursor position, every table entry and the read data are all 0.
- R2: Address 0x300 holds the 32-bit control word, which reads back unchanged. Bit 10 drives `force_blank` and bit 23 drives `cursor_off`.
- R3: `pix_depth` is selected by control bits 22:20 from the values 1, 2, 4, 8, 15, 16, 0, 0 for codes 0 to 7.
- R4: A write of d to 0x118 sets `width_px` to the low DIM_W bits of 4·d, with DIM_W = 16 by default. A read of 0x118 returns `width_px` / 4.
- R5: A write of d to 0x150 sets `height_ln` to the low DIM_W bits of d / 2, rounded down. A read of 0x150 returns 2·`height_ln`.
- R6: A write to 0x400 sets `top_offset` and a write to 0x638 sets `cursor_pos`, each as a full 32-bit value. Reads of either address return 0.
- R7: A write to an address in 0x800 to 0xFFF loads colour entry (addr − 0x800) >> 3 with R = data[23:16], G = data[15:8] and B = data[7:0]. `pix_rgb` shows that entry as {R,G,B} when `pix_index` selects it. Reads of this range return 0.
- R8: Writes to 0x508, 0x510 and 0x518 load cursor colours 0, 1 and 2 with the same packing. Reads of these addresses return {8'h00,R,G,B}, and `cur_rgb` shows the colour picked by `cur_sel`.
- R9: A write to an address in 0x1000 to 0x1FFF loads bitmap word (addr − 0x1000) >> 3 from data[15:0]. A read returns that word zero-extended, and `pat_bits` shows the word picked by `pat_index`.
- R10: Writes to 0x000, 0x108, 0x110, 0x120, 0x128, 0x130, 0x138, 0x140, 0x148, 0x158, 0x160, 0x168, 0x170 and 0x200 change no stored state. A read of any address not listed above as readable returns 0.
- R11: A high `frame_end` sets `irq` on the next edge. Any write, to any address, clears `irq` on the next edge and wins over a `frame_end` in the same cycle. With neither present, `irq` holds its value.
- R12: A write to 0x100000 clears the control word, width, height, start offset, cursor position, all three tables and `irq` on the next edge.
- R13: `bus_rdata` takes the read value at the edge where `bus_rd` is high. It is valid from that edge and holds its value while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| frame_end | input | 1 | Frame-end strobe from the timing logic |
| irq | output | 1 | Frame interrupt |
| ctrl_word | output | 32 | Stored control word |
| pix_depth | output | 5 | Decoded pixel depth in bits |
| force_blank | output | 1 | Display forced blank |
| cursor_off | output | 1 | Cursor disabled |
| width_px | output | DIM_W | Visible width in pixels |
| height_ln | output | DIM_W | Visible height in lines |
| top_offset | output | 32 | Scan-out start offset |
| cursor_pos | output | 32 | Cursor position word |
| pix_index | input | 8 | Colour table lookup index |
| pix_rgb | output | 24 | Colour table entry {R,G,B} |
| cur_sel | input | 2 | Cursor colour lookup index (0 to 2) |
| cur_rgb | output | 24 | Cursor colour {R,G,B} |
| pat_index | input | 9 | Cursor bitmap lookup index |
| pat_bits | output | 16 | Cursor bitmap word |

## Verification
The colour table is filled in full with a pattern that differs for each entry, through addresses with and without a low-bit offset. All 256 entries are then read through the lookup port, which shows that the index shift is right and that upper data bits are dropped. All 512 bitmap words are written with a scrambled value and read back over the bus and through the lookup port, so a wrong index slice or a missing zero-extension shows up. The width and height are swept over dozens of values, including odd heights and a width that overflows the field, which separates the two scalings and their inverses. All eight depth codes are tried. Timing-address writes, unmapped reads, interrupt races and soft reset are each tried against a known non-zero state.

// File: rtl/fbreg_pkg.sv
package fbreg_pkg;

  localparam int unsigned CLUT_ENTRIES = 256;
  localparam int unsigned CPAL_ENTRIES = 3;
  localparam int unsigned PAT_ENTRIES  = 512;
  localparam int unsigned CLUT_IDX_W   = $clog2(CLUT_ENTRIES);
  localparam int unsigned CPAL_IDX_W   = $clog2(CPAL_ENTRIES);
  localparam int unsigned PAT_IDX_W    = $clog2(PAT_ENTRIES);
  localparam int unsigned RGB_W        = 24;
  localparam int unsigned PAT_W        = 16;

  localparam logic [31:0] ADR_CTRL  = 32'h0000_0300;
  localparam logic [31:0] ADR_HDISP = 32'h0000_0118;
  localparam logic [31:0] ADR_VDISP = 32'h0000_0150;
  localparam logic [31:0] ADR_TOP   = 32'h0000_0400;
  localparam logic [31:0] ADR_CPOS  = 32'h0000_0638;
  localparam logic [31:0] ADR_CPAL  = 32'h0000_0508;
  localparam logic [31:0] ADR_CLUT  = 32'h0000_0800;
  localparam logic [31:0] ADR_PAT   = 32'h0000_1000;
  localparam logic [31:0] ADR_SRST  = 32'h0010_0000;

  typedef enum logic [3:0] {
    RG_NONE,
    RG_CTRL,
    RG_HDISP,
    RG_VDISP,
    RG_TOP,
    RG_CPOS,
    RG_CPAL,
    RG_CLUT,
    RG_PAT,
    RG_SRST,
    RG_TIMING
  } fb_region_e;

  function automatic logic [4:0] depth_of(input logic [2:0] code);
    case (code)
      3'd0:    depth_of = 5'd1;
      3'd1:    depth_of = 5'd2;
      3'd2:    depth_of = 5'd4;
      3'd3:    depth_of = 5'd8;
      3'd4:    depth_of = 5'd15;
      3'd5:    depth_of = 5'd16;
      default: depth_of = 5'd0;
    endcase
  endfunction

endpackage

// File: rtl/fbreg_decode.sv
module fbreg_decode
  import fbreg_pkg::*;
#(
  parameter int unsigned ADDR_W = 21
) (
  input  logic [ADDR_W-1:0]     addr,
  output fb_region_e            region,
  output logic [CLUT_IDX_W-1:0] clut_idx,
  output logic [CPAL_IDX_W-1:0] cpal_idx,
  output logic [PAT_IDX_W-1:0]  pat_idx
);

  logic [31:0] a32;

  always_comb begin
    a32      = 32'(addr);
    clut_idx = a32[3 +: CLUT_IDX_W];
    pat_idx  = a32[3 +: PAT_IDX_W];
    // 0x508 -> 0, 0x510 -> 1, 0x518 -> 2
    cpal_idx = a32[4:3] - 2'd1;

    if (a32 >= ADR_CLUT && a32 < ADR_CLUT + 32'(CLUT_ENTRIES * 8)) begin
      region = RG_CLUT;
    end else if (a32 >= ADR_PAT && a32 < ADR_PAT + 32'(PAT_ENTRIES * 8)) begin
      region = RG_PAT;
    end else if (a32 >= ADR_CPAL && a32 < ADR_CPAL + 32'(CPAL_ENTRIES * 8)) begin
      region = RG_CPAL;
    end else begin
      case (a32)
        ADR_CTRL:  region = RG_CTRL;
        ADR_HDISP: region = RG_HDISP;
        ADR_VDISP: region = RG_VDISP;
        ADR_TOP:   region = RG_TOP;
        ADR_CPOS:  region = RG_CPOS;
        ADR_SRST:  region = RG_SRST;
        32'h000, 32'h108, 32'h110, 32'h120, 32'h128, 32'h130, 32'h138,
        32'h140, 32'h148, 32'h158, 32'h160, 32'h168, 32'h170, 32'h200:
                   region = RG_TIMING;
        default:   region = RG_NONE;
      endcase
    end
  end

endmodule

// File: rtl/fbreg_table.sv
module fbreg_table #(
  parameter int unsigned ENTRIES = 256,
  parameter int unsigned DATA_W  = 24,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [IDX_W-1:0]  ridx_b,
  output logic [DATA_W-1:0] rdata_b
);

  logic [DATA_W-1:0] mem [ENTRIES];
  logic [ENTRIES-1:0] row_en;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      row_en[i] = clr || (we && (widx == IDX_W'(i)));
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_row
    logic [DATA_W-1:0] row_d;

    always_comb begin
      row_d = clr ? '0 : wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem[g] <= '0;
      end else if (row_en[g]) begin
        mem[g] <= row_d;
      end
    end
  end

  always_comb begin
    rdata_a = (32'(ridx_a) < ENTRIES) ? mem[ridx_a] : '0;
    rdata_b = (32'(ridx_b) < ENTRIES) ? mem[ridx_b] : '0;
  end

endmodule

// File: rtl/fbreg_top.sv
module fbreg_top
  import fbreg_pkg::*;
#(
  parameter int unsigned ADDR_W = 21,
  parameter int unsigned DIM_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              frame_end,
  output logic              irq,
  output logic [31:0]       ctrl_word,
  output logic [4:0]        pix_depth,
  output logic              force_blank,
  output logic              cursor_off,
  output logic [DIM_W-1:0]  width_px,
  output logic [DIM_W-1:0]  height_ln,
  output logic [31:0]       top_offset,
  output logic [31:0]       cursor_pos,
  input  logic [7:0]        pix_index,
  output logic [23:0]       pix_rgb,
  input  logic [1:0]        cur_sel,
  output logic [23:0]       cur_rgb,
  input  logic [8:0]        pat_index,
  output logic [15:0]       pat_bits
);

  localparam int unsigned CTRL_BLANK_BIT  = 10;
  localparam int unsigned CTRL_NOCURS_BIT = 23;
  localparam int unsigned CTRL_DEPTH_LSB  = 20;

  fb_region_e             region;
  logic [CLUT_IDX_W-1:0]  clut_idx;
  logic [CPAL_IDX_W-1:0]  cpal_idx;
  logic [PAT_IDX_W-1:0]   pat_idx;

  fbreg_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr     (bus_addr),
    .region   (region),
    .clut_idx (clut_idx),
    .cpal_idx (cpal_idx),
    .pat_idx  (pat_idx)
  );

  logic srst;
  logic clut_we, cpal_we, pat_we;
  logic [RGB_W-1:0] clut_bus_rd, cpal_bus_rd;
  logic [PAT_W-1:0] pat_bus_rd;
  logic unused_clut_bus;

  always_comb begin
    srst    = bus_wr && (region == RG_SRST);
    clut_we = bus_wr && (region == RG_CLUT);
    cpal_we = bus_wr && (region == RG_CPAL);
    pat_we  = bus_wr && (region == RG_PAT);
  end

  fbreg_table #(.ENTRIES(CLUT_ENTRIES), .DATA_W(RGB_W)) u_clut (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (srst),
    .we      (clut_we),
    .widx    (clut_idx),
    .wdata   (bus_wdata[RGB_W-1:0]),
    .ridx_a  (clut_idx),
    .rdata_a (clut_bus_rd),
    .ridx_b  (pix_index),
    .rdata_b (pix_rgb)
  );

  fbreg_table #(.ENTRIES(CPAL_ENTRIES), .DATA_W(RGB_W)) u_cpal (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (srst),
    .we      (cpal_we),
    .widx    (cpal_idx),
    .wdata   (bus_wdata[RGB_W-1:0]),
    .ridx_a  (cpal_idx),
    .rdata_a (cpal_bus_rd),
    .ridx_b  (cur_sel),
    .rdata_b (cur_rgb)
  );

  fbreg_table #(.ENTRIES(PAT_ENTRIES), .DATA_W(PAT_W)) u_pat (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (srst),
    .we      (pat_we),
    .widx    (pat_idx),
    .wdata   (bus_wdata[PAT_W-1:0]),
    .ridx_a  (pat_idx),
    .rdata_a (pat_bus_rd),
    .ridx_b  (pat_index),
    .rdata_b (pat_bits)
  );

  // Colour table is write-only from the bus
  assign unused_clut_bus = ^clut_bus_rd;

  // Scalar registers
  logic [31:0]      ctrl_q, ctrl_d, top_q, top_d, cpos_q, cpos_d;
  logic [DIM_W-1:0] width_q, width_d, height_q, height_d;
  logic [31:0]      rdata_q, rdata_d, rd_val;
  logic             irq_q, irq_d;
  logic             ctrl_en, width_en, height_en, top_en, cpos_en, rdata_en, irq_en;

  always_comb begin
    ctrl_en   = srst || (bus_wr && region == RG_CTRL);
    width_en  = srst || (bus_wr && region == RG_HDISP);
    height_en = srst || (bus_wr && region == RG_VDISP);
    top_en    = srst || (bus_wr && region == RG_TOP);
    cpos_en   = srst || (bus_wr && region == RG_CPOS);

    ctrl_d   = srst ? '0 : bus_wdata;
    width_d  = srst ? '0 : {bus_wdata[DIM_W-3:0], 2'b00};
    height_d = srst ? '0 : bus_wdata[DIM_W:1];
    top_d    = srst ? '0 : bus_wdata;
    cpos_d   = srst ? '0 : bus_wdata;

    // A write of any kind clears the interrupt and outranks frame end
    irq_en = bus_wr || frame_end;
    irq_d  = !bus_wr;

    case (region)
      RG_CTRL:  rd_val = ctrl_q;
      RG_HDISP: rd_val = {{(34 - DIM_W){1'b0}}, width_q[DIM_W-1:2]};
      RG_VDISP: rd_val = {{(31 - DIM_W){1'b0}}, height_q, 1'b0};
      RG_CPAL:  rd_val = {{(32 - RGB_W){1'b0}}, cpal_bus_rd};
      RG_PAT:   rd_val = {{(32 - PAT_W){1'b0}}, pat_bus_rd};
      default:  rd_val = '0;
    endcase
    rdata_en = bus_rd;
    rdata_d  = rd_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      width_q  <= '0;
      height_q <= '0;
      top_q    <= '0;
      cpos_q   <= '0;
      irq_q    <= 1'b0;
      rdata_q  <= '0;
    end else begin
      if (ctrl_en)   ctrl_q   <= ctrl_d;
      if (width_en)  width_q  <= width_d;
      if (height_en) height_q <= height_d;
      if (top_en)    top_q    <= top_d;
      if (cpos_en)   cpos_q   <= cpos_d;
      if (irq_en)    irq_q    <= irq_d;
      if (rdata_en)  rdata_q  <= rdata_d;
    end
  end

  always_comb begin
    bus_rdata   = rdata_q;
    irq         = irq_q;
    ctrl_word   = ctrl_q;
    pix_depth   = depth_of(ctrl_q[CTRL_DEPTH_LSB +: 3]);
    force_blank = ctrl_q[CTRL_BLANK_BIT];
    cursor_off  = ctrl_q[CTRL_NOCURS_BIT];
    width_px    = width_q;
    height_ln   = height_q;
    top_offset  = top_q;
    cursor_pos  = cpos_q;
  end

endmodule

// File: rtl/fbreg_chk.sv
module fbreg_chk #(
  parameter int unsigned ADDR_W = 21,
  parameter int unsigned DIM_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [31:0]       bus_rdata,
  input logic              frame_end,
  input logic              irq,
  input logic [31:0]       ctrl_word,
  input logic [4:0]        pix_depth,
  input logic [DIM_W-1:0]  width_px,
  input logic [DIM_W-1:0]  height_ln,
  input logic [31:0]       top_offset,
  input logic [31:0]       cursor_pos
);

  assert_wr_clears_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> !irq);

  assert_frame_sets_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !bus_wr) |=> irq);

  assert_irq_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_end && !bus_wr) |=> $stable(irq));

  assert_soft_reset_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && 32'(bus_addr) == 32'h0010_0000) |=>
      (ctrl_word == '0 && width_px == '0 && height_ln == '0 &&
       top_offset == '0 && cursor_pos == '0 && !irq));

  assert_rdata_holds_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  assert_depth_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_depth inside {5'd0, 5'd1, 5'd2, 5'd4, 5'd8, 5'd15, 5'd16}));

  assert_width_multiple_R4: assert property (@(posedge clk) disable iff (!rst_n)
    width_px[1:0] == 2'b00);

endmodule

bind fbreg_top fbreg_chk #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_rdata  (bus_rdata),
  .frame_end  (frame_end),
  .irq        (irq),
  .ctrl_word  (ctrl_word),
  .pix_depth  (pix_depth),
  .width_px   (width_px),
  .height_ln  (height_ln),
  .top_offset (top_offset),
  .cursor_pos (cursor_pos)
);

// File: tb/fbreg_top_test.sv
module fbreg_top_test;

  localparam int unsigned ADDR_W = 21;
  localparam int unsigned DIM_W  = 16;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [ADDR_W-1:0] bus_addr;
  logic              bus_wr, bus_rd, frame_end;
  logic [31:0]       bus_wdata, bus_rdata;
  logic              irq, force_blank, cursor_off;
  logic [31:0]       ctrl_word, top_offset, cursor_pos;
  logic [4:0]        pix_depth;
  logic [DIM_W-1:0]  width_px, height_ln;
  logic [7:0]        pix_index;
  logic [23:0]       pix_rgb, cur_rgb;
  logic [1:0]        cur_sel;
  logic [8:0]        pat_index;
  logic [15:0]       pat_bits;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  fbreg_top #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .frame_end(frame_end), .irq(irq), .ctrl_word(ctrl_word),
    .pix_depth(pix_depth), .force_blank(force_blank), .cursor_off(cursor_off),
    .width_px(width_px), .height_ln(height_ln), .top_offset(top_offset),
    .cursor_pos(cursor_pos), .pix_index(pix_index), .pix_rgb(pix_rgb),
    .cur_sel(cur_sel), .cur_rgb(cur_rgb), .pat_index(pat_index),
    .pat_bits(pat_bits)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d, input logic fe = 1'b0);
    @(negedge clk);
    bus_addr = ADDR_W'(a); bus_wdata = d; bus_wr = 1'b1; frame_end = fe;
    @(negedge clk);
    bus_wr = 1'b0; frame_end = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = ADDR_W'(a); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [4:0] exp_depth(input int c);
    case (c)
      0: return 5'd1;  1: return 5'd2;  2: return 5'd4;
      3: return 5'd8;  4: return 5'd15; 5: return 5'd16;
      default: return 5'd0;
    endcase
  endfunction

  function automatic logic [23:0] clut_val(input int i);
    logic [7:0] b = 8'(i);
    return {b, ~b, b ^ 8'h5A};
  endfunction

  function automatic logic [15:0] pat_val(input int j);
    return 16'(j * 37) ^ 16'h1234;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0;
    frame_end = 0; pix_index = '0; cur_sel = '0; pat_index = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", 32'(irq), 0);
    check("R1 ctrl", ctrl_word, 0);
    check("R1 width", 32'(width_px), 0);
    check("R1 height", 32'(height_ln), 0);
    check("R1 rdata", bus_rdata, 0);
    pix_index = 8'd255; #1 check("R1 clut", 32'(pix_rgb), 0);
    pat_index = 9'd511; #1 check("R1 pattern", 32'(pat_bits), 0);
    rd(32'h300, v); check("R1 ctrl read", v, 0);

    // R2 control word and flags
    wr(32'h300, 32'h0080_0400);
    check("R2 blank", 32'(force_blank), 1);
    check("R2 cursor off", 32'(cursor_off), 1);
    rd(32'h300, v); check("R2 readback", v, 32'h0080_0400);
    wr(32'h300, 32'hFF7F_FBFF);
    check("R2 flags low", {30'd0, force_blank, cursor_off}, 0);
    rd(32'h300, v); check("R2 readback2", v, 32'hFF7F_FBFF);

    // R3 depth codes
    for (int c = 0; c < 8; c++) begin
      wr(32'h300, 32'(c) << 20);
      check("R3 depth", 32'(pix_depth), 32'(exp_depth(c)));
    end

    // R4 width scaling
    for (int k = 0; k < 64; k++) begin
      logic [31:0] d = 32'(k * 5 + 3);
      logic [31:0] w = (d * 4) & 32'hFFFF;
      wr(32'h118, d);
      check("R4 width", 32'(width_px), w);
      rd(32'h118, v); check("R4 read", v, w >> 2);
    end
    wr(32'h118, 32'h0000_5000);
    check("R4 overflow", 32'(width_px), 32'h4000);
    rd(32'h118, v); check("R4 overflow read", v, 32'h1000);

    // R5 height scaling
    for (int k = 0; k < 64; k++) begin
      logic [31:0] d = 32'(k * 7 + 1);
      logic [31:0] h = (d >> 1) & 32'hFFFF;
      wr(32'h150, d);
      check("R5 height", 32'(height_ln), h);
      rd(32'h150, v); check("R5 read", v, h * 2);
    end

    // R6 start offset and cursor position
    wr(32'h400, 32'h0001_2340);
    wr(32'h638, 32'h0040_0020);
    check("R6 top", top_offset, 32'h0001_2340);
    check("R6 cpos", cursor_pos, 32'h0040_0020);
    rd(32'h400, v); check("R6 top read", v, 0);
    rd(32'h638, v); check("R6 cpos read", v, 0);

    // R7 colour table sweep, odd entries addressed with a +4 byte offset
    for (int i = 0; i < 256; i++)
      wr(32'h800 + 32'(i * 8) + ((i % 2 == 1) ? 32'd4 : 32'd0), {8'hA5, clut_val(i)});
    for (int i = 0; i < 256; i++) begin
      @(negedge clk); pix_index = 8'(i); #1;
      check("R7 clut", 32'(pix_rgb), 32'(clut_val(i)));
    end
    rd(32'h808, v); check("R7 read zero", v, 0);

    // R8 cursor colours
    wr(32'h508, 32'hFF11_2233);
    wr(32'h510, 32'h0044_5566);
    wr(32'h518, 32'h0077_8899);
    rd(32'h508, v); check("R8 read0", v, 32'h0011_2233);
    rd(32'h510, v); check("R8 read1", v, 32'h0044_5566);
    rd(32'h518, v); check("R8 read2", v, 32'h0077_8899);
    for (int s = 0; s < 3; s++) begin
      @(negedge clk); cur_sel = 2'(s); #1;
      check("R8 port", 32'(cur_rgb), (s == 0) ? 32'h112233 : (s == 1) ? 32'h445566 : 32'h778899);
    end

    // R9 bitmap sweep
    for (int j = 0; j < 512; j++) wr(32'h1000 + 32'(j * 8), {16'hDEAD, pat_val(j)});
    for (int j = 0; j < 512; j++) begin
      rd(32'h1000 + 32'(j * 8), v); check("R9 read", v, 32'(pat_val(j)));
      pat_index = 9'(j); #1 check("R9 port", 32'(pat_bits), 32'(pat_val(j)));
    end

    // R10 timing writes ignored, unmapped reads zero
    wr(32'h300, 32'h1234_5678);
    wr(32'h118, 32'd80);
    wr(32'h150, 32'd480);
    begin
      logic [31:0] ign [14] = '{32'h000, 32'h108, 32'h110, 32'h120, 32'h128, 32'h130,
                                32'h138, 32'h140, 32'h148, 32'h158, 32'h160, 32'h168,
                                32'h170, 32'h200};
      foreach (ign[n]) wr(ign[n], 32'hFFFF_FFFF);
    end
    check("R10 ctrl", ctrl_word, 32'h1234_5678);
    check("R10 width", 32'(width_px), 320);
    check("R10 height", 32'(height_ln), 240);
    check("R10 top", top_offset, 32'h0001_2340);
    check("R10 cpos", cursor_pos, 32'h0040_0020);
    pix_index = 8'd0; #1 check("R10 clut", 32'(pix_rgb), 32'(clut_val(0)));
    rd(32'h1000, v); check("R10 pattern", v, 32'(pat_val(0)));
    rd(32'h004, v); check("R10 unmapped", v, 0);
    rd(32'h108, v); check("R10 timing read", v, 0);
    rd(32'h2000, v); check("R10 past pattern", v, 0);
    rd(32'h100000, v); check("R10 reset read", v, 0);

    // R11 interrupt
    @(negedge clk); frame_end = 1; @(negedge clk); frame_end = 0;
    check("R11 set", 32'(irq), 1);
    repeat (3) @(negedge clk);
    check("R11 hold", 32'(irq), 1);
    wr(32'h004, 32'h0);
    check("R11 unmapped clear", 32'(irq), 0);
    @(negedge clk); frame_end = 1; @(negedge clk); frame_end = 0;
    wr(32'h108, 32'h0);
    check("R11 timing clear", 32'(irq), 0);
    wr(32'h004, 32'h0, 1'b1);
    check("R11 write wins", 32'(irq), 0);

    // R13 latency and hold
    @(negedge clk); bus_addr = ADDR_W'(32'h300); bus_rd = 1'b1;
    check("R13 before edge", bus_rdata, 0);
    @(negedge clk); bus_rd = 1'b0;
    check("R13 after edge", bus_rdata, 32'h1234_5678);
    wr(32'h300, 32'h0);
    check("R13 hold", bus_rdata, 32'h1234_5678);

    // R12 soft reset
    wr(32'h300, 32'h0000_0400);
    @(negedge clk); frame_end = 1; @(negedge clk); frame_end = 0;
    wr(32'h100000, 32'hFFFF_FFFF);
    check("R12 irq", 32'(irq), 0);
    check("R12 ctrl", ctrl_word, 0);
    check("R12 width", 32'(width_px), 0);
    check("R12 height", 32'(height_ln), 0);
    check("R12 top", top_offset, 0);
    check("R12 cpos", cursor_pos, 0);
    pix_index = 8'd77; #1 check("R12 clut", 32'(pix_rgb), 0);
    rd(32'h510, v); check("R12 cpal", v, 0);
    rd(32'h1000 + 32'(300 * 8), v); check("R12 pattern", v, 0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule